// File: doc/BRIEF.md
# Fourteen-Channel Pulse-Width DAC Bank

This block drives fourteen pulse-width outputs from one shared frame counter. Each channel has its own 8-bit width code, held in a register that is written and read back over a small register port. The port has an address, write data, a write strobe and a combinational read-data bus. In every frame a channel's output is high while the shared counter is below the channel's code, and low for the rest of the frame. An external RC filter then turns the pulse train into an analog level. Each output is presented as an open-drain pull-down enable: the pin is pulled low when the output is low, and released when the output is high.

Two global inputs shape the frame. `mode_253` selects a 253-step frame (counter 0 to 252) or a 256-step frame (counter 0 to 255). In the 253-step frame the three top codes (FDh, FEh, FFh) give an output that stays high. In the 256-step frame code FFh still goes low for one step in each frame. `rate_fast` sets the counter pace. When it is 1 the counter steps on every clock. When it is 0 the counter steps on every second clock, which halves the frame rate (about 94 kHz and about 47 kHz from a 24 MHz clock).

The pace comes from a two-state sequencer:
- ST_SKIP always moves to ST_STEP.
- ST_STEP stays in ST_STEP when `rate_fast` is 1, and returns to ST_SKIP when it is 0.
- The counter advances only in ST_STEP, and it wraps to 0 when it has reached the last step of the selected frame.
- At that wrap, each channel copies its width register into a working copy that the comparator uses. A code written in the middle of a frame therefore first shows in the next frame.

Top module: `pwm_dac_bank`

## Requirements
- R1: Width registers sit at addresses 0 to 13, one per channel. A write strobe stores the write data into the addressed register, and `reg_rdata` returns the addressed register in the same cycle. Addresses 14 and 15 read as 00h, and writes to them change no register.
- R2: After reset every width register reads 80h, and every channel runs at half duty: 128 high and 128 low steps in the 256-step frame.
- R3: With `mode_253`=1 the frame is 253 steps long, and codes FDh, FEh and FFh keep the output high through the whole frame.
- R4: With `mode_253`=0 the frame is 256 steps long, and code FFh gives 255 high steps and 1 low step in every frame.
- R5: Code 00h keeps the output low in both frame modes.
- R6: For a code c that does not saturate, the output is high for the first c steps of a frame and low for the remaining steps.
- R7: With `rate_fast`=1 one step lasts one clock. With `rate_fast`=0 one step lasts two clocks.
- R8: A width written during a frame does not change that frame's pulse; it applies from the next frame start.
- R9: `pad_pull_low[i]` is 1 when channel i's output is low and 0 when it is high (bit i belongs to channel i).
- R10: Each channel's pulse depends only on its own register; writing one channel leaves the others' pulses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address, channel index |
| reg_wdata | input | 8 | Width code to write |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rate_fast | input | 1 | 1: step every clock, 0: step every second clock |
| mode_253 | input | 1 | 1: 253-step frame, 0: 256-step frame |
| pad_pull_low | output | 14 | Open-drain pull-down enable per channel |

## Verification
The bench measures high and low run lengths between rising edges. It uses codes from the middle of the range (40h, 80h, C8h), a single-step code (01h), the codes one below each frame's saturation point (FCh in the 253-step frame, FFh in the 256-step frame), and the constant codes 00h, FDh, FEh and FFh. Together these tell apart the two frame lengths, the two paces, and a missing or extra step at either end of the comparison. A write made 20 clocks into a frame separates an update taken at the frame boundary from one taken at once. Several channels are given different codes so that any crosstalk between them shows up.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Pace sequencer: the counter advances only in ST_STEP.
    typedef enum logic {
        ST_SKIP = 1'b0,
        ST_STEP = 1'b1
    } pace_state_t;

endpackage

// File: rtl/pwm_frame_seq.sv
module pwm_frame_seq
    import pwm_bank_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_fast,
    input  logic              mode_short,
    output logic [CODE_W-1:0] cnt,
    output logic              wrap
);

    localparam logic [CODE_W-1:0] LAST_LONG  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] LAST_SHORT = LAST_LONG - CODE_W'(3);

    pace_state_t       state_q;
    pace_state_t       state_d;
    logic              step;
    logic [CODE_W-1:0] cnt_q;
    logic [CODE_W-1:0] last_step;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SKIP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SKIP: state_d = ST_STEP;
            ST_STEP: state_d = rate_fast ? ST_STEP : ST_SKIP;
            default: state_d = ST_SKIP;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        step      = (state_q == ST_STEP);
        last_step = mode_short ? LAST_SHORT : LAST_LONG;
        wrap      = step && (cnt_q >= last_step);
    end

    // Shared frame counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CODE_W'(1);
        end
    end

    assign cnt = cnt_q;

    // R7
    slow_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_fast && step) |=> !step);

    // R7
    fast_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_fast && step) |=> step);

    // R6
    count_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap) |=> (cnt_q == CODE_W'($past(cnt_q) + CODE_W'(1))));

    // R3
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_short && step && cnt_q == LAST_SHORT) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_width_regs.sv
module pwm_width_regs #(
    parameter int unsigned NUM_CH = 14,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CODE_W-1:0]             wdata,
    input  logic                          we,
    input  logic                          load,
    output logic [CODE_W-1:0]             rdata,
    output logic [NUM_CH-1:0][CODE_W-1:0] active_codes
);

    localparam logic [CODE_W-1:0] RESET_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] width_q [NUM_CH];
    logic [CODE_W-1:0] shad_q  [NUM_CH];

    // Software-visible width registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                width_q[i] <= RESET_CODE;
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (we && addr == ADDR_W'(i)) begin
                    width_q[i] <= wdata;
                end
            end
        end
    end

    // Working copies, refreshed only at a frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                shad_q[i] <= RESET_CODE;
            end
        end else if (load) begin
            for (int i = 0; i < NUM_CH; i++) begin
                shad_q[i] <= width_q[i];
            end
        end
    end

    // Read mux; unused addresses return zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = width_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign active_codes[g] = shad_q[g];

        // R1
        write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == ADDR_W'(g)) |=> (width_q[g] == $past(wdata)));

        // R8
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(shad_q[g]));
    end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int unsigned NUM_CH = 14,
    parameter int unsigned CODE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CODE_W-1:0]             cnt,
    input  logic [NUM_CH-1:0][CODE_W-1:0] codes,
    output logic [NUM_CH-1:0]             pull_low
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        logic level_hi;
        assign level_hi    = (cnt < codes[g]);
        assign pull_low[g] = !level_hi;

        // R5
        zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (codes[g] == '0) |-> pull_low[g]);
    end

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank #(
    parameter int unsigned NUM_CH = 14,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CODE_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [CODE_W-1:0] reg_rdata,
    input  logic              rate_fast,
    input  logic              mode_253,
    output logic [NUM_CH-1:0] pad_pull_low
);

    localparam logic [CODE_W-1:0] LAST_LONG  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] LAST_SHORT = LAST_LONG - CODE_W'(3);

    logic [CODE_W-1:0]             frame_cnt;
    logic                          frame_wrap;
    logic [NUM_CH-1:0][CODE_W-1:0] active_codes;

    pwm_frame_seq #(
        .CODE_W(CODE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_fast (rate_fast),
        .mode_short(mode_253),
        .cnt       (frame_cnt),
        .wrap      (frame_wrap)
    );

    pwm_width_regs #(
        .NUM_CH(NUM_CH),
        .CODE_W(CODE_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .we          (reg_we),
        .load        (frame_wrap),
        .rdata       (reg_rdata),
        .active_codes(active_codes)
    );

    pwm_compare #(
        .NUM_CH(NUM_CH),
        .CODE_W(CODE_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (frame_cnt),
        .codes   (active_codes),
        .pull_low(pad_pull_low)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_top_chk
        // R3
        sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_253 && frame_cnt <= LAST_SHORT && active_codes[g] > LAST_SHORT)
            |-> !pad_pull_low[g]);

        // R4
        top_low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_253 && active_codes[g] == LAST_LONG && frame_cnt == LAST_LONG)
            |-> pad_pull_low[g]);
    end

endmodule

// File: tb/pwm_dac_bank_test.sv
`timescale 1ns/1ps
module pwm_dac_bank_test;

    localparam int KIND_PULSE = 0;
    localparam int KIND_HIGH  = 1;
    localparam int KIND_LOW   = 2;

    typedef struct {
        int    ch;
        int    kind;
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        rate_fast = 1'b1;
    logic        mode_253 = 1'b0;
    logic [13:0] pad_pull_low;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    pwm_dac_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata),
        .rate_fast   (rate_fast),
        .mode_253    (mode_253),
        .pad_pull_low(pad_pull_low)
    );

    always #10 clk = ~clk;

    function automatic logic level(input int ch);
        return !pad_pull_low[ch];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr  = 4'(a);
        reg_wdata = 8'(d);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    // Wait for a rising edge on ch; returns 0 on timeout
    task automatic find_rise(input int ch, output bit found);
        logic prev;
        logic cur;
        found = 1'b0;
        @(negedge clk);
        prev = level(ch);
        for (int k = 0; k < 4096; k++) begin
            @(negedge clk);
            cur = level(ch);
            if (!prev && cur) begin
                found = 1'b1;
                break;
            end
            prev = cur;
        end
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        bit found;
        hi = -1;
        lo = -1;
        find_rise(ch, found);
        if (found) begin
            hi = 1;
            forever begin
                @(negedge clk);
                if (!level(ch) || hi > 4096) break;
                hi++;
            end
            lo = 1;
            forever begin
                @(negedge clk);
                if (level(ch) || lo > 4096) break;
                lo++;
            end
        end
    endtask

    // Driver: queue one expected item and wait until the monitor has used it
    task automatic expect_item(input int ch, input int kind, input int hi, input int lo,
                               input string tag);
        exp_t e;
        e.ch = ch; e.kind = kind; e.hi = hi; e.lo = lo; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: pop expected items and compare with the pads
    initial begin
        exp_t e;
        int   hi;
        int   lo;
        int   bad;
        forever begin
            wait (sb_q.size() > 0);
            e = sb_q[0];
            if (e.kind == KIND_PULSE) begin
                measure(e.ch, hi, lo);
                check(hi == e.hi, {e.tag, " high run"}, hi, e.hi);
                check(lo == e.lo, {e.tag, " low run"}, lo, e.lo);
            end else begin
                repeat (520) @(negedge clk);
                bad = 0;
                for (int k = 0; k < 1040; k++) begin
                    @(negedge clk);
                    if (level(e.ch) != (e.kind == KIND_HIGH)) bad++;
                end
                check(bad == 0, {e.tag, " constant level"}, bad, 0);
            end
            void'(sb_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        int hi;
        int lo;
        bit found;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset value of every register
        for (int i = 0; i < 14; i++) begin
            rd(i, d);
            check(d == 8'h80, "R2 reset register value", d, 8'h80);
        end
        // R1: unused addresses read zero
        rd(14, d);
        check(d == 0, "R1 unused address 14 read", d, 0);
        rd(15, d);
        check(d == 0, "R1 unused address 15 read", d, 0);

        // R2, R6: mid-scale after reset, 256-step frame, fast pace
        expect_item(0, KIND_PULSE, 128, 128, "R2 R6 ch0 reset pulse");

        // R1, R10: distinct codes on several channels
        wr(3, 8'h40);
        wr(7, 8'h01);
        wr(13, 8'hC8);
        rd(3, d);
        check(d == 8'h40, "R1 readback ch3", d, 8'h40);
        rd(7, d);
        check(d == 8'h01, "R1 readback ch7", d, 8'h01);
        rd(13, d);
        check(d == 8'hC8, "R1 readback ch13", d, 8'hC8);
        expect_item(3, KIND_PULSE, 64, 192, "R6 R10 ch3 code 40h");
        expect_item(7, KIND_PULSE, 1, 255, "R6 ch7 code 01h");
        expect_item(13, KIND_PULSE, 200, 56, "R6 R10 ch13 code C8h");
        expect_item(0, KIND_PULSE, 128, 128, "R10 ch0 untouched");

        // R4: full-scale code in the 256-step frame
        wr(5, 8'hFF);
        expect_item(5, KIND_PULSE, 255, 1, "R4 ch5 code FFh");
        // R5: zero code, 256-step frame
        wr(6, 8'h00);
        expect_item(6, KIND_LOW, 0, 0, "R5 R9 ch6 code 00h");

        // R7: slow pace doubles every step
        rate_fast = 1'b0;
        expect_item(3, KIND_PULSE, 128, 384, "R7 ch3 slow pace");
        expect_item(7, KIND_PULSE, 2, 510, "R7 ch7 slow pace");
        rate_fast = 1'b1;

        // R3: 253-step frame
        mode_253 = 1'b1;
        wr(8, 8'hFD);
        wr(9, 8'hFE);
        wr(10, 8'hFC);
        expect_item(3, KIND_PULSE, 64, 189, "R3 R6 ch3 short frame");
        expect_item(10, KIND_PULSE, 252, 1, "R3 ch10 code FCh");
        expect_item(5, KIND_HIGH, 0, 0, "R3 R9 ch5 code FFh saturates");
        expect_item(8, KIND_HIGH, 0, 0, "R3 ch8 code FDh saturates");
        expect_item(9, KIND_HIGH, 0, 0, "R3 ch9 code FEh saturates");
        expect_item(6, KIND_LOW, 0, 0, "R5 ch6 code 00h short frame");

        // R1: writes to an unused address change nothing
        wr(14, 8'h33);
        rd(14, d);
        check(d == 0, "R1 unused address write ignored", d, 0);
        rd(0, d);
        check(d == 8'h80, "R1 ch0 unchanged after unused write", d, 8'h80);
        expect_item(0, KIND_PULSE, 128, 125, "R1 ch0 pulse after unused write");

        // R8: a write during a frame applies only from the next frame
        mode_253 = 1'b0;
        repeat (600) @(negedge clk);
        find_rise(0, found);
        hi = 1;
        forever begin
            @(negedge clk);
            if (hi == 20) begin
                reg_addr  = 4'd0;
                reg_wdata = 8'h05;
                reg_we    = 1'b1;
            end else begin
                reg_we = 1'b0;
            end
            if (!level(0) || hi > 4096) break;
            hi++;
        end
        reg_we = 1'b0;
        check(hi == 128, "R8 current frame keeps old width", hi, 128);
        expect_item(0, KIND_PULSE, 5, 251, "R8 new width next frame");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule